// File: doc/BRIEF.md
# Switch Matrix Control Register Bank

This block holds the control state for an analog switch matrix made of four banks, each with eight switches. Software reaches it through a byte-wide register port. The port has a write strobe, a read strobe and a registered read path. A serial bus slave sits in front of this port in the full system. Each bank has two registers. The live register drives the bank's switch-enable bits directly. The staged register holds a pattern that only reaches the switches when a commit command runs.

Two command registers each carry a pair of 4-bit opcodes, one for each bank of a pair. An opcode can do one of four things:
- close exactly one switch and open all others in the bank;
- open the whole bank;
- commit the staged pattern into the live register;
- leave the bank alone.

Both opcodes of one command write act on the same clock edge. This lets two banks switch together. The block also presents the 7-bit bus address that the serial engine should answer to. A strap pin selects between two addresses.

The live register is the only state of each bank. The state has two holding conditions and four transitions:
- Holding happens when no access targets the bank, or when an opcode of 10 to 15 targets it.
- A direct write loads the written byte.
- Opcodes 0 to 7 load a one-hot pattern.
- Opcode 8 loads zero.
- Opcode 9 loads the staged value.

Top module: `swm_ctrl`

## Requirements
- R1: Reset clears every live and staged register to 0x00, so all switch outputs are open and every register reads 0x00.
- R2: A write to address 0x00+b (b = 0..3 for banks A..D) updates bank b's switch outputs at the next clock edge. A read of that address returns the live value. Switch n of a bank is bit n-1 of its byte, and bank b occupies sw_state[8b+7:8b].
- R3: A write to address 0x10+b stores a staged byte for bank b, which reads back at that address and leaves every switch output unchanged.
- R4: Command opcode k in 0..7 sets the bank to exactly bit k closed and all other bits open.
- R5: Command opcode 8 opens every switch of the bank.
- R6: Command opcode 9 copies the bank's staged byte into its live register.
- R7: Command opcodes 10 to 15 leave the bank unchanged.
- R8: The command register at 0x14 carries bank A's opcode in bits 3:0 and bank B's in bits 7:4. The one at 0x15 does the same for banks C and D. Both fields act on the same edge, and the other pair of banks is untouched.
- R9: Reads of 0x14 and 0x15 always return 0x00.
- R10: Reads of any unmapped address return 0x00, and writes to one change no register and no output.
- R11: rdata carries the read result in the cycle after rd_en and is 0x00 in any cycle that follows no read. When a read and a write hit the same register in one cycle, the read returns the value from before the write.
- R12: dev_addr is 0x74 when addr_strap is 0 and 0x75 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| addr_strap | input | 1 | Selects bus address low bit |
| dev_addr | output | 7 | Bus address for the serial engine |
| sw_state | output | 32 | Switch enables, bank b at bits 8b+7:8b |

## Verification
Two of the block's functions can coincide in one cycle, because wr_en and rd_en are independent strobes: a register update and a read of that same register. The bench raises both strobes together on a live address. It expects rdata to show the old byte and sw_state to show the new byte afterwards. It repeats this on a staged address. It then reads the same address again, with no write, to confirm that the new value landed.

// File: rtl/swm_pkg.sv
package swm_pkg;
    localparam int CODE_W = 4;
    localparam logic [3:0] OP_OPEN_ALL = 4'd8;
    localparam logic [3:0] OP_COMMIT   = 4'd9;
    localparam logic [7:0] LIVE_BASE   = 8'h00;
    localparam logic [7:0] STAGE_BASE  = 8'h10;
    localparam logic [7:0] CMD_BASE    = 8'h14;
    localparam logic [6:0] BUS_ADDR_LO = 7'h74;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_SELECT,
        ACT_CLEAR,
        ACT_COMMIT
    } bank_act_e;
endpackage

// File: rtl/swm_cmd_decode.sv
module swm_cmd_decode
    import swm_pkg::*;
#(
    parameter int SW = 8,
    localparam int SEL_W = $clog2(SW)
) (
    input  logic              cmd_we,
    input  logic [CODE_W-1:0] cmd_code,
    output bank_act_e         act,
    output logic [SEL_W-1:0]  sel
);
    always_comb begin
        sel = cmd_code[SEL_W-1:0];
        if (!cmd_we)
            act = ACT_HOLD;
        else if (int'(cmd_code) < SW)
            act = ACT_SELECT;
        else if (cmd_code == OP_OPEN_ALL)
            act = ACT_CLEAR;
        else if (cmd_code == OP_COMMIT)
            act = ACT_COMMIT;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/swm_bank.sv
module swm_bank
    import swm_pkg::*;
#(
    parameter int SW = 8,
    localparam int SEL_W = $clog2(SW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live_we,
    input  logic              stage_we,
    input  logic [SW-1:0]     wdata,
    input  logic              cmd_we,
    input  logic [CODE_W-1:0] cmd_code,
    output logic [SW-1:0]     live_q,
    output logic [SW-1:0]     stage_q
);
    bank_act_e        act;
    logic [SEL_W-1:0] sel;
    logic [SW-1:0]    live_d;

    swm_cmd_decode #(.SW(SW)) u_dec (
        .cmd_we   (cmd_we),
        .cmd_code (cmd_code),
        .act      (act),
        .sel      (sel)
    );

    always_comb begin
        live_d = live_q;
        if (live_we)
            live_d = wdata;
        else begin
            unique case (act)
                ACT_HOLD:   live_d = live_q;
                ACT_SELECT: live_d = SW'(1) << sel;
                ACT_CLEAR:  live_d = '0;
                ACT_COMMIT: live_d = stage_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= '0;
            stage_q <= '0;
        end else begin
            live_q <= live_d;
            if (stage_we)
                stage_q <= wdata;
        end
    end

    // R4: a select opcode leaves exactly one switch closed
    p_select_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !live_we && int'(cmd_code) < SW) |=> ($countones(live_q) == 1));
    // R5
    p_open_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !live_we && cmd_code == OP_OPEN_ALL) |=> (live_q == '0));
    // R6
    p_commit_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !live_we && cmd_code == OP_COMMIT) |=> (live_q == $past(stage_q)));
    // R7
    p_noop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !live_we && cmd_code > OP_COMMIT) |=> $stable(live_q));
    // R3: staging alone never moves the outputs
    p_stage_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!live_we && !cmd_we) |=> $stable(live_q));
endmodule

// File: rtl/swm_read_port.sv
module swm_read_port
    import swm_pkg::*;
#(
    parameter int NB = 4,
    parameter int SW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [NB*SW-1:0] live_flat,
    input  logic [NB*SW-1:0] stage_flat,
    output logic [SW-1:0]    rdata
);
    logic [SW-1:0] sel_d;

    always_comb begin
        sel_d = '0;
        for (int b = 0; b < NB; b++) begin
            if (addr == LIVE_BASE + 8'(b))
                sel_d = live_flat[b*SW +: SW];
            if (addr == STAGE_BASE + 8'(b))
                sel_d = stage_flat[b*SW +: SW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd_en ? sel_d : '0;
    end

    // R11: no read, no data
    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));
    // R9: command registers read as zero
    p_cmd_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == CMD_BASE || addr == CMD_BASE + 8'd1)) |=> (rdata == '0));
endmodule

// File: rtl/swm_ctrl.sv
module swm_ctrl
    import swm_pkg::*;
#(
    parameter int NB = 4,
    parameter int SW = 8,
    localparam int FLAT_W = NB * SW,
    localparam int NPAIR = NB / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr,
    input  logic [SW-1:0]     wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [SW-1:0]     rdata,
    input  logic              addr_strap,
    output logic [6:0]        dev_addr,
    output logic [FLAT_W-1:0] sw_state
);
    logic [FLAT_W-1:0] live_flat;
    logic [FLAT_W-1:0] stage_flat;
    logic [NB-1:0]     live_we;
    logic [NB-1:0]     cmd_hit;

    assign dev_addr = BUS_ADDR_LO | 7'(addr_strap);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam int PAIR = b / 2;
        localparam int HALF = b % 2;
        logic stage_we;
        assign live_we[b] = wr_en && (addr == LIVE_BASE + 8'(b));
        assign stage_we   = wr_en && (addr == STAGE_BASE + 8'(b));
        assign cmd_hit[b] = wr_en && (addr == CMD_BASE + 8'(PAIR));

        swm_bank #(.SW(SW)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .live_we  (live_we[b]),
            .stage_we (stage_we),
            .wdata    (wdata),
            .cmd_we   (cmd_hit[b]),
            .cmd_code (wdata[HALF*CODE_W +: CODE_W]),
            .live_q   (live_flat[b*SW +: SW]),
            .stage_q  (stage_flat[b*SW +: SW])
        );
    end

    swm_read_port #(.NB(NB), .SW(SW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .addr       (addr),
        .live_flat  (live_flat),
        .stage_flat (stage_flat),
        .rdata      (rdata)
    );

    assign sw_state = live_flat;

    // R8: a command write touches only its own pair of banks
    p_pair_isolation_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CMD_BASE) |=> (sw_state[FLAT_W-1:2*SW] == $past(sw_state[FLAT_W-1:2*SW])));
    // R10: writes outside the map leave outputs alone
    p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > CMD_BASE + 8'(NPAIR - 1)) |=> $stable(sw_state));
    // R12
    p_dev_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dev_addr == (addr_strap ? 7'h75 : 7'h74));
endmodule

// File: tb/swm_ctrl_test.sv
`timescale 1ns/1ps
module swm_ctrl_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  addr = 0;
    logic [7:0]  wdata = 0;
    logic        wr_en = 0;
    logic        rd_en = 0;
    logic [7:0]  rdata;
    logic        addr_strap = 0;
    logic [6:0]  dev_addr;
    logic [31:0] sw_state;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] m_live [4];
    logic [7:0] m_stage[4];

    always #2.5 clk = ~clk;

    swm_ctrl uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .addr_strap(addr_strap),
        .dev_addr(dev_addr), .sw_state(sw_state)
    );

    function automatic logic [7:0] apply_op(logic [7:0] cur, logic [7:0] stg, logic [3:0] code);
        if (code < 8) return 8'(1) << code;
        if (code == 8) return 8'h00;
        if (code == 9) return stg;
        return cur;
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        if (a < 8'h04) return m_live[a[1:0]];
        if (a >= 8'h10 && a < 8'h14) return m_stage[a[1:0]];
        return 8'h00;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(string req);
        check(req, sw_state, {m_live[3], m_live[2], m_live[1], m_live[0]});
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        if (a < 8'h04) m_live[a[1:0]] = d;
        else if (a >= 8'h10 && a < 8'h14) m_stage[a[1:0]] = d;
        else if (a == 8'h14 || a == 8'h15) begin
            int p = (a == 8'h15) ? 2 : 0;
            m_live[p]   = apply_op(m_live[p],   m_stage[p],   d[3:0]);
            m_live[p+1] = apply_op(m_live[p+1], m_stage[p+1], d[7:4]);
        end
    endtask

    task automatic do_read(logic [7:0] a, string req);
        logic [7:0] e;
        @(negedge clk);
        addr = a; rd_en = 1;
        e = exp_read(a);
        @(negedge clk);
        rd_en = 0;
        check(req, 32'(rdata), 32'(e));
        @(negedge clk);
        check("R11 idle rdata", 32'(rdata), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250427));
        for (int i = 0; i < 4; i++) begin m_live[i] = 0; m_stage[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_outputs("R1 reset outputs");
        for (int i = 0; i < 4; i++) do_read(8'h10 + 8'(i), "R1 reset stage");
        check("R11 rdata after reset", 32'(rdata), 0);
        // R12 strap
        check("R12 strap0", 32'(dev_addr), 32'h74);
        addr_strap = 1; #1;
        check("R12 strap1", 32'(dev_addr), 32'h75);
        addr_strap = 0;
        // R2 live writes, bit mapping
        do_write(8'h00, 8'h06); check_outputs("R2 bank A");
        do_write(8'h03, 8'h80); check_outputs("R2 bank D");
        do_read(8'h00, "R2 readback");
        // R3 staging isolated
        do_write(8'h11, 8'h5A); check_outputs("R3 stage no effect");
        do_read(8'h11, "R3 stage readback");
        // R4 / R8 pair A,B
        do_write(8'h14, 8'h72); check_outputs("R4 R8 select A=2 B=7");
        // R5 / R7
        do_write(8'h14, 8'hF8); check_outputs("R5 R7 clear A hold B");
        // R6 commit both of pair C,D
        do_write(8'h12, 8'hC3); do_write(8'h13, 8'h3C);
        do_write(8'h15, 8'h99); check_outputs("R6 commit C D");
        do_write(8'h15, 8'hBA); check_outputs("R7 codes 10 11");
        // R9
        do_read(8'h14, "R9 cmd read"); do_read(8'h15, "R9 cmd read");
        // R10 unmapped
        do_write(8'h04, 8'hFF); do_write(8'h16, 8'h00); do_write(8'hFF, 8'h12);
        check_outputs("R10 unmapped write");
        for (int i = 0; i < 4; i++) do_read(8'h10 + 8'(i), "R10 stage untouched");
        do_read(8'h04, "R10 unmapped read"); do_read(8'h20, "R10 unmapped read");
        // R11 same-cycle read and write
        @(negedge clk);
        addr = 8'h01; wdata = 8'hA5; wr_en = 1; rd_en = 1;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check("R11 read sees old live", 32'(rdata), 32'(m_live[1]));
        m_live[1] = 8'hA5;
        check_outputs("R11 write landed");
        do_read(8'h01, "R11 reread live");
        @(negedge clk);
        addr = 8'h12; wdata = 8'h0F; wr_en = 1; rd_en = 1;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check("R11 read sees old stage", 32'(rdata), 32'(m_stage[2]));
        m_stage[2] = 8'h0F;
        do_read(8'h12, "R11 reread stage");
        // random mix
        for (int n = 0; n < 400; n++) begin
            int op = $urandom_range(0, 4);
            logic [7:0] d = 8'($urandom);
            logic [1:0] b = 2'($urandom_range(0, 3));
            case (op)
                0: begin do_write(8'h00 + 8'(b), d); check_outputs("R2 random live"); end
                1: begin do_write(8'h10 + 8'(b), d); check_outputs("R3 random stage"); end
                2: begin do_write(8'h14 + 8'(b[0]), d); check_outputs("R8 random cmd"); end
                3: do_read(8'($urandom_range(0, 31)), "R10 random read");
                default: begin do_write(8'($urandom_range(22, 255)), d); check_outputs("R10 random unmapped"); end
            endcase
        end
        // R1 reset again clears everything
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < 4; i++) begin m_live[i] = 0; m_stage[i] = 0; end
        @(negedge clk);
        check_outputs("R1 second reset");
        do_read(8'h13, "R1 second reset stage");
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule